// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block sits beside a control store and decides, once per clock, which control word runs next. Each control word carries a select field, one shared branch-target field and a condition selector. The sequencer combines these with a vector of status flags and the opcode held in the instruction register. From them it forms the next control address and drives it out combinationally. On the clock edge it loads that address into a current-address register, which is the index used to read the control store.

Several kinds of control flow share the one target field:
- stepping to the following word;
- an unconditional jump;
- a jump taken only when the chosen status flag is 1;
- a dispatch into a four-word slot picked by the opcode;
- a microsubroutine call and return.

The call and return work through a small return-address stack. A call that finds the stack full, or a return that finds it empty, sets a sticky error indication.

Top module: `mseq_sequencer`

## Requirements
- R1: While `rstN` is low and after its release, `curAddr` is 0 and `stackErr` is 0, and the return stack is empty.
- R2: On each rising clock edge outside reset, `curAddr` takes the value `nextAddr` had just before that edge.
- R3: Select code 0 (and the unused codes 6 and 7) gives `nextAddr = curAddr + 1`, wrapping from 127 to 0.
- R4: Select code 1 gives `nextAddr = addrField`.
- R5: Select code 2 gives `nextAddr = addrField` when `flags[condSel]` is 1. Otherwise it gives `curAddr + 1`.
- R6: Select code 3 gives `nextAddr = {opcode, 2'b00}`, so each opcode owns four consecutive words.
- R7: Select code 4 gives `nextAddr = addrField` and pushes `curAddr + 1` onto a 4-entry return stack.
- R8: Select code 5 gives `nextAddr` equal to the most recently pushed, not yet popped return address, and pops it. Nested calls unwind in LIFO order.
- R9: Select code 5 with an empty stack gives `nextAddr = 0`. `stackErr` becomes 1 after that edge and stays 1 until reset.
- R10: Select code 4 with a full stack still gives `nextAddr = addrField`. The return address is not saved, the four stacked entries are unchanged, and `stackErr` becomes 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| selField | input | 3 | Next-address select code from the current control word |
| addrField | input | 7 | Branch / call target from the current control word |
| condSel | input | 2 | Index of the status flag tested by a conditional jump |
| flags | input | 4 | Status flags from the datapath |
| opcode | input | 5 | Opcode from the instruction register |
| nextAddr | output | 7 | Combinational next control address |
| curAddr | output | 7 | Registered current control address |
| stackErr | output | 1 | Sticky return-stack misuse flag |

## Verification
`nextAddr` is valid in the same cycle as the control word, flags and opcode that produce it, with no register on the way. The bench drives each step just after a rising edge and samples `nextAddr` 2 ns later. `curAddr` and `stackErr` change one edge later, so they are sampled 2 ns after the following rising edge. A vector table walks every select code from reset through a nested call pair and an address wrap. Directed sequences then cover the empty-return and full-call cases, and include reset checks.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  // Control-word select codes; unused codes behave as increment.
  typedef enum logic [2:0] {
    SEL_INC  = 3'd0,
    SEL_JUMP = 3'd1,
    SEL_CJMP = 3'd2,
    SEL_MAP  = 3'd3,
    SEL_CALL = 3'd4,
    SEL_RET  = 3'd5
  } selT;

  // Source of the next address inside the datapath mux.
  typedef enum logic [2:0] {
    SRC_SEQ   = 3'd0,
    SRC_FIELD = 3'd1,
    SRC_MAP   = 3'd2,
    SRC_STACK = 3'd3,
    SRC_ZERO  = 3'd4
  } srcT;

  // Strobes from control to datapath.
  typedef struct packed {
    srcT  src;
    logic push;
    logic pop;
    logic errSet;
  } ctrlT;

endpackage

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
#(
  parameter int FLAG_W = 4,
  localparam int CSEL_W = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input  logic [2:0]        selField,
  input  logic [CSEL_W-1:0] condSel,
  input  logic [FLAG_W-1:0] flags,
  input  logic              stackEmpty,
  input  logic              stackFull,
  output ctrlT              strobes
);

  logic condHit;

  assign condHit = flags[condSel];

  always_comb begin
    strobes = '{src: SRC_SEQ, push: 1'b0, pop: 1'b0, errSet: 1'b0};
    case (selField)
      SEL_JUMP: strobes.src = SRC_FIELD;
      SEL_CJMP: strobes.src = condHit ? SRC_FIELD : SRC_SEQ;
      SEL_MAP:  strobes.src = SRC_MAP;
      SEL_CALL: begin
        strobes.src    = SRC_FIELD;
        strobes.push   = !stackFull;
        strobes.errSet = stackFull;
      end
      SEL_RET: begin
        strobes.src    = stackEmpty ? SRC_ZERO : SRC_STACK;
        strobes.pop    = !stackEmpty;
        strobes.errSet = stackEmpty;
      end
      default:  strobes.src = SRC_SEQ;
    endcase
  end

endmodule

// File: rtl/mseq_stack.sv
module mseq_stack #(
  parameter int DATA_W = 7,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] topData,
  output logic              empty,
  output logic              full
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  count;
  logic [PTR_W-1:0]  wrIdx;
  logic [PTR_W-1:0]  topIdx;

  assign empty  = (count == '0);
  assign full   = (count == CNT_W'(DEPTH));
  assign wrIdx  = PTR_W'(count);
  assign topIdx = PTR_W'(count - CNT_W'(1));
  assign topData = empty ? '0 : mem[topIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (push && !full) begin
      count <= count + CNT_W'(1);
    end else if (pop && !empty) begin
      count <= count - CNT_W'(1);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        mem[e] <= '0;
      end else if (push && !full && wrIdx == PTR_W'(e)) begin
        mem[e] <= pushData;
      end
    end
  end

endmodule

// File: rtl/mseq_datapath.sv
module mseq_datapath
  import mseq_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int SLOT_BITS = 2,
  parameter int DEPTH     = 4,
  localparam int OPC_W    = ADDR_W - SLOT_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              strobes,
  input  logic [ADDR_W-1:0] addrField,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              stackEmpty,
  output logic              stackFull,
  output logic              stackErr
);

  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] mapAddr;
  logic [ADDR_W-1:0] retAddr;

  assign seqAddr = curAddr + ADDR_W'(1);
  assign mapAddr = {opcode, {SLOT_BITS{1'b0}}};

  mseq_stack #(
    .DATA_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) i_stack (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobes.push),
    .pop      (strobes.pop),
    .pushData (seqAddr),
    .topData  (retAddr),
    .empty    (stackEmpty),
    .full     (stackFull)
  );

  always_comb begin
    case (strobes.src)
      SRC_FIELD: nextAddr = addrField;
      SRC_MAP:   nextAddr = mapAddr;
      SRC_STACK: nextAddr = retAddr;
      SRC_ZERO:  nextAddr = '0;
      default:   nextAddr = seqAddr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      stackErr <= 1'b0;
    end else begin
      curAddr <= nextAddr;
      if (strobes.errSet) stackErr <= 1'b1;
    end
  end

endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
  import mseq_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int SLOT_BITS = 2,
  parameter int FLAG_W    = 4,
  parameter int DEPTH     = 4,
  localparam int OPC_W    = ADDR_W - SLOT_BITS,
  localparam int CSEL_W   = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        selField,
  input  logic [ADDR_W-1:0] addrField,
  input  logic [CSEL_W-1:0] condSel,
  input  logic [FLAG_W-1:0] flags,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] nextAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic              stackErr
);

  ctrlT strobes;
  logic stackEmpty;
  logic stackFull;

  mseq_ctrl #(
    .FLAG_W (FLAG_W)
  ) i_ctrl (
    .selField   (selField),
    .condSel    (condSel),
    .flags      (flags),
    .stackEmpty (stackEmpty),
    .stackFull  (stackFull),
    .strobes    (strobes)
  );

  mseq_datapath #(
    .ADDR_W    (ADDR_W),
    .SLOT_BITS (SLOT_BITS),
    .DEPTH     (DEPTH)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .addrField  (addrField),
    .opcode     (opcode),
    .nextAddr   (nextAddr),
    .curAddr    (curAddr),
    .stackEmpty (stackEmpty),
    .stackFull  (stackFull),
    .stackErr   (stackErr)
  );

endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
  parameter int ADDR_W    = 7,
  parameter int SLOT_BITS = 2,
  parameter int FLAG_W    = 4,
  localparam int OPC_W    = ADDR_W - SLOT_BITS,
  localparam int CSEL_W   = (FLAG_W > 1) ? $clog2(FLAG_W) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        selField,
  input logic [ADDR_W-1:0] addrField,
  input logic [CSEL_W-1:0] condSel,
  input logic [FLAG_W-1:0] flags,
  input logic [OPC_W-1:0]  opcode,
  input logic [ADDR_W-1:0] nextAddr,
  input logic [ADDR_W-1:0] curAddr,
  input logic              stackErr
);

  AST_RESET_STATE: assert property (@(posedge clk) !rstN |=> (curAddr == '0 && !stackErr)); // R1
  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rstN) 1'b1 |=> curAddr == $past(nextAddr)); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN) (selField == 3'd0 || selField >= 3'd6) |-> nextAddr == ADDR_W'(curAddr + ADDR_W'(1))); // R3
  AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (!rstN) selField == 3'd1 |-> nextAddr == addrField); // R4
  AST_CJMP_TAKEN: assert property (@(posedge clk) disable iff (!rstN) (selField == 3'd2 && flags[condSel]) |-> nextAddr == addrField); // R5
  AST_CJMP_FALL: assert property (@(posedge clk) disable iff (!rstN) (selField == 3'd2 && !flags[condSel]) |-> nextAddr == ADDR_W'(curAddr + ADDR_W'(1))); // R5
  AST_MAP_SLOT: assert property (@(posedge clk) disable iff (!rstN) selField == 3'd3 |-> nextAddr == {opcode, {SLOT_BITS{1'b0}}}); // R6
  AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rstN) selField == 3'd4 |-> nextAddr == addrField); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN) stackErr |=> stackErr); // R9

endmodule

bind mseq_sequencer mseq_checker #(
  .ADDR_W    (ADDR_W),
  .SLOT_BITS (SLOT_BITS),
  .FLAG_W    (FLAG_W)
) i_mseq_checker (
  .clk       (clk),
  .rstN      (rstN),
  .selField  (selField),
  .addrField (addrField),
  .condSel   (condSel),
  .flags     (flags),
  .opcode    (opcode),
  .nextAddr  (nextAddr),
  .curAddr   (curAddr),
  .stackErr  (stackErr)
);

// File: tb/test_mseq_sequencer.sv
module test_mseq_sequencer;

  typedef struct packed {
    logic [2:0] sel;
    logic [6:0] addr;
    logic [1:0] cond;
    logic [3:0] flg;
    logic [4:0] opc;
    logic [6:0] expNext;
  } stepT;

  localparam int NSTEP = 20;
  localparam stepT STEPS [NSTEP] = '{
    '{3'd0, 7'd0,   2'd0, 4'b0000, 5'd0,  7'd1},    // R3 inc
    '{3'd0, 7'd0,   2'd0, 4'b0000, 5'd0,  7'd2},    // R3 inc
    '{3'd1, 7'd20,  2'd0, 4'b0000, 5'd0,  7'd20},   // R4 jump
    '{3'd2, 7'd40,  2'd1, 4'b0010, 5'd0,  7'd40},   // R5 taken
    '{3'd2, 7'd60,  2'd2, 4'b0010, 5'd0,  7'd41},   // R5 not taken
    '{3'd2, 7'd90,  2'd3, 4'b1000, 5'd0,  7'd90},   // R5 top flag
    '{3'd3, 7'd99,  2'd0, 4'b0000, 5'd5,  7'd20},   // R6 map
    '{3'd4, 7'd100, 2'd0, 4'b0000, 5'd0,  7'd100},  // R7 call, push 21
    '{3'd4, 7'd110, 2'd0, 4'b0000, 5'd0,  7'd110},  // R7 call, push 101
    '{3'd0, 7'd0,   2'd0, 4'b0000, 5'd0,  7'd111},  // R3
    '{3'd5, 7'd5,   2'd0, 4'b0000, 5'd0,  7'd101},  // R8 inner return
    '{3'd5, 7'd5,   2'd0, 4'b0000, 5'd0,  7'd21},   // R8 outer return
    '{3'd3, 7'd0,   2'd0, 4'b0000, 5'd31, 7'd124},  // R6 top slot
    '{3'd0, 7'd0,   2'd0, 4'b0000, 5'd0,  7'd125},  // R3
    '{3'd1, 7'd127, 2'd0, 4'b0000, 5'd0,  7'd127},  // R4
    '{3'd0, 7'd0,   2'd0, 4'b0000, 5'd0,  7'd0},    // R3 wrap
    '{3'd6, 7'd50,  2'd0, 4'b1111, 5'd0,  7'd1},    // R3 unused code
    '{3'd7, 7'd50,  2'd0, 4'b1111, 5'd0,  7'd2},    // R3 unused code
    '{3'd2, 7'd70,  2'd0, 4'b1110, 5'd0,  7'd3},    // R5 flag0 low
    '{3'd2, 7'd70,  2'd0, 4'b0001, 5'd0,  7'd70}    // R5 flag0 high
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] selField = '0;
  logic [6:0] addrField = '0;
  logic [1:0] condSel = '0;
  logic [3:0] flags = '0;
  logic [4:0] opcode = '0;
  logic [6:0] nextAddr;
  logic [6:0] curAddr;
  logic       stackErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  mseq_sequencer i_mseq_sequencer (
    .clk       (clk),
    .rstN      (rstN),
    .selField  (selField),
    .addrField (addrField),
    .condSel   (condSel),
    .flags     (flags),
    .opcode    (opcode),
    .nextAddr  (nextAddr),
    .curAddr   (curAddr),
    .stackErr  (stackErr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one control word right after an edge, check nextAddr, then the register.
  task automatic step(input logic [2:0] s, input logic [6:0] a, input logic [1:0] c,
                      input logic [3:0] f, input logic [4:0] o,
                      input int expNext, input int expErr, input string req);
    selField = s; addrField = a; condSel = c; flags = f; opcode = o;
    #2;
    check({req, " nextAddr"}, int'(nextAddr), expNext);
    @(posedge clk); #2;
    check({"R2 curAddr after ", req}, int'(curAddr), expNext);
    check({req, " stackErr"}, int'(stackErr), expErr);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    selField = '0; addrField = '0; condSel = '0; flags = '0; opcode = '0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 curAddr in reset", int'(curAddr), 0);
    check("R1 stackErr in reset", int'(stackErr), 0);
    rstN = 1'b1;
    @(posedge clk); #2;
    check("R1 curAddr after release", int'(curAddr), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset; with increment held, one edge after release curAddr is 1.
    doReset();
    // Re-enter reset to start the table from address 0.
    rstN = 1'b0;
    @(posedge clk); #2;
    check("R1 curAddr re-reset", int'(curAddr), 0);
    rstN = 1'b1;
    for (int i = 0; i < NSTEP; i++) begin
      step(STEPS[i].sel, STEPS[i].addr, STEPS[i].cond, STEPS[i].flg, STEPS[i].opc,
           int'(STEPS[i].expNext), 0, $sformatf("table step %0d", i));
    end

    // R9: return with an empty stack.
    rstN = 1'b0;
    @(posedge clk); #2;
    rstN = 1'b1;
    step(3'd1, 7'd33, 2'd0, 4'd0, 5'd0, 33, 0, "R4 pre");
    step(3'd5, 7'd77, 2'd0, 4'd0, 5'd0, 0, 1, "R9 empty return");
    step(3'd0, 7'd0,  2'd0, 4'd0, 5'd0, 1, 1, "R9 sticky");
    step(3'd4, 7'd12, 2'd0, 4'd0, 5'd0, 12, 1, "R9 sticky after call");
    step(3'd5, 7'd0,  2'd0, 4'd0, 5'd0, 2, 1, "R8 after error");

    // R10: fill four entries, then call again.
    rstN = 1'b0;
    @(posedge clk); #2;
    check("R1 stackErr cleared", int'(stackErr), 0);
    rstN = 1'b1;
    step(3'd4, 7'd10, 2'd0, 4'd0, 5'd0, 10, 0, "R7 call1");
    step(3'd4, 7'd20, 2'd0, 4'd0, 5'd0, 20, 0, "R7 call2");
    step(3'd4, 7'd30, 2'd0, 4'd0, 5'd0, 30, 0, "R7 call3");
    step(3'd4, 7'd40, 2'd0, 4'd0, 5'd0, 40, 0, "R7 call4");
    step(3'd4, 7'd50, 2'd0, 4'd0, 5'd0, 50, 1, "R10 call on full");
    step(3'd5, 7'd0,  2'd0, 4'd0, 5'd0, 31, 1, "R10 R8 pop4");
    step(3'd5, 7'd0,  2'd0, 4'd0, 5'd0, 21, 1, "R8 pop3");
    step(3'd5, 7'd0,  2'd0, 4'd0, 5'd0, 11, 1, "R8 pop2");
    step(3'd5, 7'd0,  2'd0, 4'd0, 5'd0, 1,  1, "R8 pop1");
    step(3'd5, 7'd0,  2'd0, 4'd0, 5'd0, 0,  1, "R9 drained return");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule